// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Sequencer

This block walks a three-dimensional block of memory one byte at a time and issues a source and destination byte address for every byte. A transfer has three counts: the bytes in a row, the rows in a frame and the frames in the transfer. Each side, source and destination, has its own signed row stride and signed frame stride. The byte offset inside a row always counts up by one.

One trigger moves exactly one frame. Frames that follow need further triggers. A trigger can come from the trigger pin, from the block's own self-chain path, or, in queue mode, from a write to the frame-count register. Completion is reported in two separate pending flags, one for intermediate frames and one for the final frame. Each flag can be enabled onto a single interrupt line. A chain pulse goes out after every intermediate frame.

Software loads the parameter set through a small register write port. Writing the frame-count register arms the channel. The byte requests leave through a valid/ready handshake that carries both addresses and a flag marking the last byte of each frame.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, req_valid, irq, chain_out, busy, pend_final, pend_mid, evt_miss and cnt_err are 0 and frames_left is 0.
- R2: Registers are at cfg_addr 0 (source base), 1 (destination base), 2 (row byte count in bits 15:0, row count in bits 31:16), 3 (row strides) and 4 (frame strides). In registers 3 and 4 the source stride is in bits 15:0 and the destination stride in bits 31:16, each as 16-bit two's complement. Byte k of row r of frame f goes out with source address = src_base + f*src_frame_stride + r*src_row_stride + k, taken modulo 2^32. The destination address follows the same rule with the destination values. Bytes go out with k varying fastest, then r, then f.
- R3: One trigger produces exactly ACNT*BCNT accepted beats, and req_last is high on the final beat only. The frame then ends, frames_left drops by one, and no further beat is offered until the next trigger.
- R4: Writing cfg_addr 6 loads frames_left with bits 15:0 and resets the frame position to the base addresses. While frames_left is 0, triggers produce no beats and no flag changes.
- R5: If option bit 2 (self-chain) is set in cfg_addr 5, the end of each non-final frame pulses chain_out for one cycle and starts the next frame with no external trigger. A C-frame transfer then needs one trigger and gives C-1 chain pulses.
- R6: The end of the final frame sets pend_final, and the end of any other frame sets pend_mid. irq = (pend_final AND option bit 0) OR (pend_mid AND option bit 1).
- R7: A write to cfg_addr 7 clears pend_final (bit 0), pend_mid (bit 1), evt_miss (bit 2) and cnt_err (bit 3) for each data bit that is 1. Flags whose bit is 0 are unchanged.
- R8: A trigger that arrives while a frame is in progress is held and starts the next frame once the current frame ends. A second trigger arriving while one is already held sets evt_miss and is dropped.
- R9: When option bit 3 (queue mode) is set, writing 1 to cfg_addr 6 arms one frame and starts it with no trigger. Writing any other value sets cnt_err and leaves frames_left at 0.
- R10: While req_valid is high and req_ready is low, req_valid stays high and req_src and req_dst hold their values.
- R11: If the row byte count or the row count is 0, a triggered frame ends with no beats but still counts as a completed frame for frames_left, the pending flags and chain_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| trig | input | 1 | External frame trigger, one pulse per frame |
| req_ready | input | 1 | Downstream accepts the current byte request |
| req_valid | output | 1 | Byte request valid |
| req_src | output | 32 | Source byte address |
| req_dst | output | 32 | Destination byte address |
| req_last | output | 1 | Final byte of the current frame |
| chain_out | output | 1 | One-cycle chain trigger after an intermediate frame |
| irq | output | 1 | Enabled completion interrupt |
| frames_left | output | 16 | Frames still to run |
| pend_final | output | 1 | Final-frame completion pending |
| pend_mid | output | 1 | Intermediate-frame completion pending |
| evt_miss | output | 1 | A trigger was lost while one was already held |
| cnt_err | output | 1 | Queue-mode frame count other than 1 was written |
| busy | output | 1 | A frame is running or a trigger is held |

## Verification
A wrong stride sign extension or a wrong row or frame base update shows up on the very first beat of the affected row or frame. A stale byte or row counter moves req_last off the final byte and changes the number of beats in the frame. A wrong frame counter or a lost held trigger shows up as a missing frame, an extra frame or a wrong chain pulse count, within a few cycles of the frame boundary. Flag and mask errors appear on irq, the pending flags and the error flags one cycle after the completion or write that should have changed them.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  // register indices
  localparam logic [2:0] RA_SRC   = 3'd0;
  localparam logic [2:0] RA_DST   = 3'd1;
  localparam logic [2:0] RA_DIMS  = 3'd2;
  localparam logic [2:0] RA_ROWS  = 3'd3;
  localparam logic [2:0] RA_FRMS  = 3'd4;
  localparam logic [2:0] RA_OPT   = 3'd5;
  localparam logic [2:0] RA_CNT   = 3'd6;
  localparam logic [2:0] RA_CLR   = 3'd7;

  // option bits
  localparam int OPT_FIN_IRQ = 0;
  localparam int OPT_MID_IRQ = 1;
  localparam int OPT_CHAIN   = 2;
  localparam int OPT_QUEUE   = 3;
  localparam int OPT_W       = 4;

  // clear bits
  localparam int CLR_FIN  = 0;
  localparam int CLR_MID  = 1;
  localparam int CLR_MISS = 2;
  localparam int CLR_CERR = 3;
  localparam int CLR_W    = 4;

endpackage

// File: rtl/dma3d_regs.sv
module dma3d_regs
  import dma3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     dst_base,
  output logic [CW-1:0]     acnt,
  output logic [CW-1:0]     bcnt,
  output logic [SW-1:0]     src_rs,
  output logic [SW-1:0]     dst_rs,
  output logic [SW-1:0]     src_fs,
  output logic [SW-1:0]     dst_fs,
  output logic [OPT_W-1:0]  opts,
  output logic              arm,
  output logic [CW-1:0]     arm_cnt,
  output logic              qtrig,
  output logic              cerr_set,
  output logic [CLR_W-1:0]  clr
);
  localparam int HALF = AW / 2;

  logic cnt_ok;
  logic qtrig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      acnt     <= '0;
      bcnt     <= '0;
      src_rs   <= '0;
      dst_rs   <= '0;
      src_fs   <= '0;
      dst_fs   <= '0;
      opts     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_SRC:  src_base <= cfg_wdata;
        RA_DST:  dst_base <= cfg_wdata;
        RA_DIMS: begin
          acnt <= cfg_wdata[CW-1:0];
          bcnt <= cfg_wdata[HALF +: CW];
        end
        RA_ROWS: begin
          src_rs <= cfg_wdata[SW-1:0];
          dst_rs <= cfg_wdata[HALF +: SW];
        end
        RA_FRMS: begin
          src_fs <= cfg_wdata[SW-1:0];
          dst_fs <= cfg_wdata[HALF +: SW];
        end
        RA_OPT:  opts <= cfg_wdata[OPT_W-1:0];
        default: ;
      endcase
    end
  end

  // frame-count write arms the channel; queue mode only accepts a count of one
  assign arm      = cfg_we && (cfg_addr == RA_CNT);
  assign cnt_ok   = !opts[OPT_QUEUE] || (cfg_wdata[CW-1:0] == CW'(1));
  assign arm_cnt  = cnt_ok ? cfg_wdata[CW-1:0] : '0;
  assign cerr_set = arm && !cnt_ok;
  assign clr      = (cfg_we && (cfg_addr == RA_CLR)) ? cfg_wdata[CLR_W-1:0] : '0;

  // queue trigger fires the cycle after the count is loaded
  always_ff @(posedge clk) begin
    if (!rst_n) qtrig_q <= 1'b0;
    else        qtrig_q <= arm && opts[OPT_QUEUE] && cnt_ok;
  end
  assign qtrig = qtrig_q;

endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          start,
  input  logic          beat,
  input  logic          frame_adv,
  input  logic [CW-1:0] acnt,
  input  logic [CW-1:0] bcnt,
  input  logic [SW-1:0] src_rs,
  input  logic [SW-1:0] dst_rs,
  input  logic [SW-1:0] src_fs,
  input  logic [SW-1:0] dst_fs,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          last_beat,
  output logic          dims_zero
);

  function automatic logic [AW-1:0] widen_stride(input logic [SW-1:0] s);
    return {{(AW-SW){s[SW-1]}}, s};
  endfunction

  function automatic logic [AW-1:0] add_stride(input logic [AW-1:0] a,
                                               input logic [SW-1:0] s);
    return a + widen_stride(s);
  endfunction

  function automatic logic [AW-1:0] add_offset(input logic [AW-1:0] a,
                                               input logic [CW-1:0] k);
    return a + {{(AW-CW){1'b0}}, k};
  endfunction

  logic [AW-1:0] fsrc_q, fdst_q;   // frame base
  logic [AW-1:0] rsrc_q, rdst_q;   // row base
  logic [CW-1:0] k_q, r_q;
  logic          row_end;

  assign row_end   = (k_q == acnt - CW'(1));
  assign last_beat = row_end && (r_q == bcnt - CW'(1));
  assign dims_zero = (acnt == '0) || (bcnt == '0);
  assign src_addr  = add_offset(rsrc_q, k_q);
  assign dst_addr  = add_offset(rdst_q, k_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsrc_q <= '0;
      fdst_q <= '0;
    end else if (arm) begin
      fsrc_q <= src_base;
      fdst_q <= dst_base;
    end else if (frame_adv) begin
      fsrc_q <= add_stride(fsrc_q, src_fs);
      fdst_q <= add_stride(fdst_q, dst_fs);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsrc_q <= '0;
      rdst_q <= '0;
      k_q    <= '0;
      r_q    <= '0;
    end else if (start) begin
      rsrc_q <= fsrc_q;
      rdst_q <= fdst_q;
      k_q    <= '0;
      r_q    <= '0;
    end else if (beat) begin
      if (row_end) begin
        k_q    <= '0;
        r_q    <= r_q + CW'(1);
        rsrc_q <= add_stride(rsrc_q, src_rs);
        rdst_q <= add_stride(rdst_q, dst_rs);
      end else begin
        k_q <= k_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             qtrig,
  input  logic             arm,
  input  logic [CW-1:0]    arm_cnt,
  input  logic             cerr_set,
  input  logic [CLR_W-1:0] clr,
  input  logic [OPT_W-1:0] opts,
  input  logic             dims_zero,
  input  logic             req_ready,
  input  logic             last_beat,
  output logic             req_valid,
  output logic             beat,
  output logic             start,
  output logic             frame_adv,
  output logic             chain_out,
  output logic [CW-1:0]    frames_left,
  output logic             pend_final,
  output logic             pend_mid,
  output logic             evt_miss,
  output logic             cnt_err,
  output logic             busy,
  output logic             irq
);

  seq_state_t    state_q;
  logic          held_q;
  logic [CW-1:0] frames_q;
  logic          final_frame;
  logic          evt;

  assign req_valid   = (state_q == ST_RUN);
  assign beat        = req_valid && req_ready;
  assign frame_adv   = (state_q == ST_DONE);
  assign final_frame = (frames_q == CW'(1));
  assign chain_out   = frame_adv && opts[OPT_CHAIN] && !final_frame;
  assign evt         = trig || qtrig || chain_out;
  assign start       = (state_q == ST_IDLE) && (frames_q != '0) && (evt || held_q);
  assign busy        = (state_q != ST_IDLE) || held_q;
  assign frames_left = frames_q;
  assign irq         = (pend_final && opts[OPT_FIN_IRQ]) || (pend_mid && opts[OPT_MID_IRQ]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      held_q   <= 1'b0;
      frames_q <= '0;
      evt_miss <= 1'b0;
    end else begin
      if (clr[CLR_MISS]) evt_miss <= 1'b0;
      // a trigger during a frame is held once; a second one is lost
      if ((state_q != ST_IDLE) && evt) begin
        if (held_q) evt_miss <= 1'b1;
        else        held_q   <= 1'b1;
      end
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= dims_zero ? ST_DONE : ST_RUN;
            held_q  <= 1'b0;
          end else if (frames_q == '0) begin
            held_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (beat && last_beat) state_q <= ST_DONE;
        end
        ST_DONE: begin
          frames_q <= frames_q - CW'(1);
          state_q  <= ST_IDLE;
          if (final_frame) held_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (arm) frames_q <= arm_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_final <= 1'b0;
      pend_mid   <= 1'b0;
      cnt_err    <= 1'b0;
    end else begin
      pend_final <= (pend_final && !clr[CLR_FIN]) || (frame_adv && final_frame);
      pend_mid   <= (pend_mid && !clr[CLR_MID]) || (frame_adv && !final_frame);
      cnt_err    <= (cnt_err && !clr[CLR_CERR]) || cerr_set;
    end
  end

endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          trig,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic          req_last,
  output logic          chain_out,
  output logic          irq,
  output logic [CW-1:0] frames_left,
  output logic          pend_final,
  output logic          pend_mid,
  output logic          evt_miss,
  output logic          cnt_err,
  output logic          busy
);

  logic [AW-1:0]    src_base, dst_base;
  logic [CW-1:0]    acnt, bcnt;
  logic [SW-1:0]    src_rs, dst_rs, src_fs, dst_fs;
  logic [OPT_W-1:0] opts;
  logic             arm, qtrig, cerr_set;
  logic [CW-1:0]    arm_cnt;
  logic [CLR_W-1:0] clr;
  logic             beat, start, frame_adv, last_beat, dims_zero;

  dma3d_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_base(src_base), .dst_base(dst_base),
    .acnt(acnt), .bcnt(bcnt), .src_rs(src_rs), .dst_rs(dst_rs),
    .src_fs(src_fs), .dst_fs(dst_fs), .opts(opts), .arm(arm),
    .arm_cnt(arm_cnt), .qtrig(qtrig), .cerr_set(cerr_set), .clr(clr)
  );

  dma3d_addr_gen #(.AW(AW), .CW(CW), .SW(SW)) u_addr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .src_base(src_base),
    .dst_base(dst_base), .start(start), .beat(beat), .frame_adv(frame_adv),
    .acnt(acnt), .bcnt(bcnt), .src_rs(src_rs), .dst_rs(dst_rs),
    .src_fs(src_fs), .dst_fs(dst_fs), .src_addr(req_src), .dst_addr(req_dst),
    .last_beat(last_beat), .dims_zero(dims_zero)
  );

  dma3d_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .qtrig(qtrig), .arm(arm),
    .arm_cnt(arm_cnt), .cerr_set(cerr_set), .clr(clr), .opts(opts),
    .dims_zero(dims_zero), .req_ready(req_ready), .last_beat(last_beat),
    .req_valid(req_valid), .beat(beat), .start(start), .frame_adv(frame_adv),
    .chain_out(chain_out), .frames_left(frames_left), .pend_final(pend_final),
    .pend_mid(pend_mid), .evt_miss(evt_miss), .cnt_err(cnt_err),
    .busy(busy), .irq(irq)
  );

  assign req_last = req_valid && last_beat;

endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk
  import dma3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [AW-1:0] cfg_wdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_src,
  input logic [AW-1:0] req_dst,
  input logic          req_last,
  input logic          chain_out,
  input logic          irq,
  input logic [CW-1:0] frames_left,
  input logic          pend_final,
  input logic          pend_mid,
  input logic          evt_miss,
  input logic          busy,
  input logic          frame_done
);

  logic cnt_wr, miss_clr;
  assign cnt_wr   = cfg_we && (cfg_addr == RA_CNT);
  assign miss_clr = cfg_we && (cfg_addr == RA_CLR) && cfg_wdata[CLR_MISS];

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst));

  a_r3_last_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_last |=> !req_valid);

  a_r3_frame_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !cnt_wr |=> frames_left == $past(frames_left) - CW'(1));

  a_r5_chain_continues: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out && !cnt_wr |=> busy && frames_left != '0);

  a_r4_empty_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frames_left == '0 && !busy |=> !req_valid);

  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_final || pend_mid);

  a_r8_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss && !miss_clr |=> evt_miss);

endmodule

bind dma3d_seq dma3d_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .req_last(req_last),
  .chain_out(chain_out), .irq(irq), .frames_left(frames_left),
  .pend_final(pend_final), .pend_mid(pend_mid), .evt_miss(evt_miss),
  .busy(busy), .frame_done(frame_adv)
);

// File: tb/dma3d_seq_tb.sv
`timescale 1ns/1ps
module dma3d_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        trig;
  logic        req_ready;
  logic        req_valid;
  logic [31:0] req_src, req_dst;
  logic        req_last, chain_out, irq;
  logic [15:0] frames_left;
  logic        pend_final, pend_mid, evt_miss, cnt_err, busy;

  always #2 clk = ~clk;

  dma3d_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig(trig), .req_ready(req_ready),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .req_last(req_last), .chain_out(chain_out), .irq(irq),
    .frames_left(frames_left), .pend_final(pend_final), .pend_mid(pend_mid),
    .evt_miss(evt_miss), .cnt_err(cnt_err), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // model of the transfer in flight
  logic [31:0] m_sb, m_db;
  int m_a, m_b, m_srs, m_drs, m_sfs, m_dfs;
  int mf, mk, mr;
  int beats, chains;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_prev = 1'b0;
  logic [31:0] prev_src, prev_dst;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive ready and watch the request port between edges
  always begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: req_ready = 1'b1;
      1: req_ready = lfsr[0];
      default: req_ready = 1'b0;
    endcase
    #1;
    if (rst_n === 1'b1) begin
      if (hold_prev) begin
        chk("R10 valid held", {31'd0, req_valid}, 32'd1);
        chk("R10 src held", req_src, prev_src);
        chk("R10 dst held", req_dst, prev_dst);
      end
      hold_prev = req_valid && !req_ready;
      prev_src  = req_src;
      prev_dst  = req_dst;
      if (chain_out) chains++;
      if (req_valid && req_ready) begin
        chk("R2 src", req_src, m_sb + 32'(mf * m_sfs + mr * m_srs + mk));
        chk("R2 dst", req_dst, m_db + 32'(mf * m_dfs + mr * m_drs + mk));
        chk("R3 last", {31'd0, req_last}, {31'd0, (mk == m_a - 1) && (mr == m_b - 1)});
        beats++;
        if (mk == m_a - 1) begin
          mk = 0;
          if (mr == m_b - 1) begin mr = 0; mf++; end
          else mr++;
        end else mk++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arm(input int c);
    mf = 0; mk = 0; mr = 0;
    wr(3'd6, 32'(c));
  endtask

  task automatic setup(input logic [31:0] sb, input logic [31:0] db, input int a,
                       input int b, input int srs, input int drs, input int sfs,
                       input int dfs, input logic [3:0] opt, input int c);
    m_sb = sb; m_db = db; m_a = a; m_b = b;
    m_srs = srs; m_drs = drs; m_sfs = sfs; m_dfs = dfs;
    beats = 0; chains = 0;
    wr(3'd0, sb);
    wr(3'd1, db);
    wr(3'd2, {16'(b), 16'(a)});
    wr(3'd3, {16'(drs), 16'(srs)});
    wr(3'd4, {16'(dfs), 16'(sfs)});
    wr(3'd5, {28'd0, opt});
    wr(3'd7, 32'hF);
    arm(c);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int n = 0;
    while (q < 6 && n < 5000) begin
      @(negedge clk); #1;
      if (!busy && !req_valid) q++; else q = 0;
      n++;
    end
    if (n >= 5000) chk("R3 transfer never settled", 32'(n), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; trig = 1'b0;
    req_ready = 1'b0;
    m_sb = 0; m_db = 0; m_a = 1; m_b = 1; m_srs = 0; m_drs = 0; m_sfs = 0; m_dfs = 0;
    mf = 0; mk = 0; mr = 0; beats = 0; chains = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 chain_out", {31'd0, chain_out}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 frames_left", {16'd0, frames_left}, 32'd0);
    chk("R1 flags", {28'd0, pend_final, pend_mid, evt_miss, cnt_err}, 32'd0);

    // R2 R3 R5 R6: sweep of dimensions with self-chaining
    for (int a = 1; a <= 3; a++)
      for (int b = 1; b <= 3; b++)
        for (int c = 1; c <= 3; c++) begin
          ready_mode = (a + b + c) % 2;
          setup(32'h1000_0000 + 32'(a * 256 + b * 16), 32'hFFFF_FFF0 - 32'(c * 64),
                a, b, a + 2, -(a * 5), b * 7 + 40, -3, 4'b0111, c);
          pulse_trig();
          wait_quiet();
          chk("R3 beats per transfer", 32'(beats), 32'(a * b * c));
          chk("R5 chain pulses", 32'(chains), 32'(c - 1));
          chk("R4 frames_left empty", {16'd0, frames_left}, 32'd0);
          chk("R6 pend_final", {31'd0, pend_final}, 32'd1);
          chk("R6 pend_mid", {31'd0, pend_mid}, {31'd0, c > 1});
          chk("R6 irq", {31'd0, irq}, 32'd1);
        end

    // R3 R6: manual triggers, no chaining, no enables
    ready_mode = 0;
    setup(32'h2000, 32'h8000, 3, 2, 16, 1280, 48, 16, 4'b0000, 2);
    pulse_trig();
    wait_quiet();
    chk("R3 one frame per trigger", 32'(beats), 32'd6);
    chk("R3 frames_left after one", {16'd0, frames_left}, 32'd1);
    chk("R6 pend_mid after first", {31'd0, pend_mid}, 32'd1);
    chk("R6 pend_final not yet", {31'd0, pend_final}, 32'd0);
    chk("R6 irq masked", {31'd0, irq}, 32'd0);
    chk("R5 no chain when disabled", 32'(chains), 32'd0);
    pulse_trig();
    wait_quiet();
    chk("R3 second frame", 32'(beats), 32'd12);
    chk("R6 pend_final after last", {31'd0, pend_final}, 32'd1);
    chk("R6 irq still masked", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'd3);
    #1;
    chk("R6 irq after enable", {31'd0, irq}, 32'd1);
    // R7 selective clear
    wr(3'd7, 32'd1);
    #1;
    chk("R7 pend_final cleared", {31'd0, pend_final}, 32'd0);
    chk("R7 pend_mid kept", {31'd0, pend_mid}, 32'd1);
    chk("R7 irq from mid", {31'd0, irq}, 32'd1);
    wr(3'd7, 32'd2);
    #1;
    chk("R7 pend_mid cleared", {31'd0, pend_mid}, 32'd0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);

    // R4 trigger ignored when empty, then re-armed
    pulse_trig();
    wait_quiet();
    chk("R4 no beats when empty", 32'(beats), 32'd12);
    chk("R4 no flag when empty", {30'd0, pend_final, pend_mid}, 32'd0);
    arm(1);
    #1;
    chk("R4 re-armed count", {16'd0, frames_left}, 32'd1);
    pulse_trig();
    wait_quiet();
    chk("R4 re-armed frame from base", 32'(beats), 32'd18);

    // R8 held trigger
    ready_mode = 2;
    setup(32'h3000, 32'h4000, 2, 2, 4, 8, 100, 200, 4'b0001, 2);
    pulse_trig();
    pulse_trig();
    #1;
    chk("R8 busy with held trigger", {31'd0, busy}, 32'd1);
    ready_mode = 0;
    wait_quiet();
    chk("R8 held trigger ran frame", 32'(beats), 32'd8);
    chk("R8 no miss", {31'd0, evt_miss}, 32'd0);
    chk("R8 frames_left", {16'd0, frames_left}, 32'd0);

    // R8 lost trigger
    ready_mode = 2;
    setup(32'h5000, 32'h6000, 2, 2, 4, 8, 100, 200, 4'b0001, 3);
    pulse_trig();
    pulse_trig();
    pulse_trig();
    ready_mode = 0;
    wait_quiet();
    chk("R8 only two frames", 32'(beats), 32'd8);
    chk("R8 miss flagged", {31'd0, evt_miss}, 32'd1);
    chk("R8 frames_left", {16'd0, frames_left}, 32'd1);
    wr(3'd7, 32'd4);
    #1;
    chk("R7 miss cleared", {31'd0, evt_miss}, 32'd0);
    chk("R7 pend_mid kept", {31'd0, pend_mid}, 32'd1);
    pulse_trig();
    wait_quiet();
    chk("R8 third frame", 32'(beats), 32'd12);

    // R9 queue mode
    ready_mode = 1;
    setup(32'h7000, 32'h9000, 2, 2, -2, 16, 0, 0, 4'b1001, 1);
    wait_quiet();
    chk("R9 queue write starts frame", 32'(beats), 32'd4);
    chk("R9 pend_final", {31'd0, pend_final}, 32'd1);
    chk("R9 no count error", {31'd0, cnt_err}, 32'd0);
    arm(3);
    wait_quiet();
    chk("R9 bad count flagged", {31'd0, cnt_err}, 32'd1);
    chk("R9 bad count not armed", {16'd0, frames_left}, 32'd0);
    chk("R9 bad count no beats", 32'(beats), 32'd4);
    wr(3'd7, 32'd8);
    #1;
    chk("R7 cnt_err cleared", {31'd0, cnt_err}, 32'd0);

    // R11 empty rows
    ready_mode = 0;
    setup(32'h100, 32'h200, 0, 2, 1, 1, 1, 1, 4'b0111, 2);
    pulse_trig();
    wait_quiet();
    chk("R11 no beats", 32'(beats), 32'd0);
    chk("R11 frames consumed", {16'd0, frames_left}, 32'd0);
    chk("R11 flags", {30'd0, pend_final, pend_mid}, 32'd3);
    chk("R11 chain pulse", 32'(chains), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule